// File: doc/BRIEF.md
# Flash Write-Completion Poller

This block runs on the host side of a byte-wide flash device. Another part of the system issues a program or erase command. This block then finds out when the device has finished the operation. It reads one address over and over through a simple request/acknowledge read port until the device shows that its internal write has ended. It then reads the location again to confirm that the stored byte is the one expected, and reports the outcome as a single-cycle pulse: done, fail or timeout.

An input selects one of four completion tests:

- **Inverted-MSB polling.** While the device is busy it returns the complement of bit 7. This mode also waits a settle interval before the confirming read.
- **Bit-6 toggle watch.**
- **Two identical successive reads.**
- **Timer only.** The block issues no reads while it waits the worst-case time for the operation.

A confirming read can land exactly when the device finishes. To cover that race, a mismatching confirmation gets two more reads, and both must be correct for the operation to pass.

Top module: `flash_done_poller`

## Requirements
- R1: With `mode`=0, the poll ends on the first read whose bit 7 equals bit 7 of the expected byte. At least `SETTLE_CYC` cycles then pass before the confirming read is requested.
- R2: With `mode`=1, the poll ends on the first read whose bit 6 equals bit 6 of the read just before it in the same operation. The first read of an operation never ends the poll.
- R3: With `mode`=2, the poll ends on the first read whose whole byte equals the previous read of the same operation.
- R4: With `mode`=3, no read is issued during the wait. The wait lasts at least `PROG_WAIT_CYC` cycles when `op_erase`=0 and at least `ERASE_WAIT_CYC` cycles when `op_erase`=1. Exactly one confirming read follows the wait.
- R5: When `op_erase`=1 the expected byte is FFh and `wdata` is ignored. Otherwise the expected byte is `wdata`.
- R6: The block pulses done when the confirming read equals the expected byte. When it does not, the block makes exactly two more reads. It pulses done if both match, and pulses fail on the first of them that does not.
- R7: If the poll has not ended `poll_limit` cycles after start, the block pulses timeout and issues no confirming read.
- R8: `done`, `fail` and `timeout` are never high together. Each is high for one cycle, while `busy` is low. All are low after reset.
- R9: `start` is accepted only while `busy` is low. A start raised during an operation changes neither the address nor the outcome of that operation.
- R10: Once `rd_req` rises, it stays high with a stable `rd_addr` (the address latched at start) until a cycle with `rd_ack` high, in which `rd_data` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin waiting for an operation (taken when idle) |
| mode | input | 2 | 0 MSB poll, 1 toggle, 2 repeat read, 3 timer only |
| op_erase | input | 1 | 1 = sector erase, 0 = byte program |
| addr | input | ADDR_W | Location to poll and verify |
| wdata | input | 8 | Byte that was programmed |
| poll_limit | input | LIM_W | Cycle budget for the polling phase |
| rd_req | output | 1 | Read request to the flash port |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge; rd_data valid |
| rd_data | input | 8 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pass pulse |
| fail | output | 1 | One-cycle verify-failure pulse |
| timeout | output | 1 | One-cycle poll-timeout pulse |

## Verification
The hardest state to reach is the retry path. In it, the completion test has already passed, but the low data bits are still stale, so the confirming read mismatches. The bench's flash model returns a chosen number of "stale" bytes after the busy phase. These bytes have the correct bit 7 but a wrong bit 0. Two stale bytes drive the block through a failed confirmation into a passing retry, and three make the first retry read fail. The toggle mode depends on whether the first post-busy read happens to repeat the last busy bit 6. The bench works out which read count to expect from the busy length and the true byte.

// File: rtl/pwc_pkg.sv
`timescale 1ns/1ps
package pwc_pkg;
  typedef enum logic [1:0] {
    MD_INVBIT = 2'd0,
    MD_TOGGLE = 2'd1,
    MD_REPEAT = 2'd2,
    MD_TIMER  = 2'd3
  } det_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_SETTLE,
    ST_WAIT,
    ST_CHECK,
    ST_RECHECK
  } pwc_state_t;
endpackage

// File: rtl/pwc_delay.sv
`timescale 1ns/1ps
// Loadable down-counter; expired is high while the count is zero.
module pwc_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] count,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= count;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pwc_detect.sv
`timescale 1ns/1ps
// Completion test for the three read-based modes.
module pwc_detect
  import pwc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clear,
  input  logic      sample,
  input  det_mode_t mode,
  input  logic [7:0] rdata,
  input  logic      exp_msb,
  output logic      hit
);
  logic [7:0] prev_q;
  logic       have_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      have_q <= 1'b0;
      prev_q <= '0;
    end else if (sample) begin
      have_q <= 1'b1;
      prev_q <= rdata;
    end
  end

  always_comb begin
    unique case (mode)
      MD_INVBIT: hit = (rdata[7] == exp_msb);
      MD_TOGGLE: hit = have_q && (rdata[6] == prev_q[6]);
      MD_REPEAT: hit = have_q && (rdata == prev_q);
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_done_poller.sv
`timescale 1ns/1ps
module flash_done_poller
  import pwc_pkg::*;
#(
  parameter int ADDR_W         = 19,
  parameter int LIM_W          = 20,
  parameter int SETTLE_CYC     = 125,
  parameter int PROG_WAIT_CYC  = 5000,
  parameter int ERASE_WAIT_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              op_erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [LIM_W-1:0]  poll_limit,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              timeout
);
  localparam int MAX_A  = (ERASE_WAIT_CYC > PROG_WAIT_CYC) ? ERASE_WAIT_CYC : PROG_WAIT_CYC;
  localparam int MAX_WT = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int DW     = $clog2(MAX_WT + 1);
  localparam logic [7:0] ERASED = 8'hFF;

  pwc_state_t        state_q;
  det_mode_t         mode_q;
  det_mode_t         mode_in;
  logic [7:0]        exp_q;
  logic [ADDR_W-1:0] addr_q;
  logic              second_q;
  logic              req_q, done_q, fail_q, to_q;

  logic              take, hit, launch;
  logic              dly_load, dly_exp, lim_exp;
  logic [DW-1:0]     dly_count;

  assign mode_in = det_mode_t'(mode);
  assign take    = req_q && rd_ack;
  assign launch  = (state_q == ST_IDLE) && start;

  pwc_detect u_detect (
    .clk     (clk),
    .rst     (rst),
    .clear   (launch),
    .sample  ((state_q == ST_POLL) && take),
    .mode    (mode_q),
    .rdata   (rd_data),
    .exp_msb (exp_q[7]),
    .hit     (hit)
  );

  // Shared wait counter: worst-case operation time or post-poll settle.
  always_comb begin
    dly_load  = 1'b0;
    dly_count = DW'(SETTLE_CYC);
    if (launch && mode_in == MD_TIMER) begin
      dly_load  = 1'b1;
      dly_count = op_erase ? DW'(ERASE_WAIT_CYC) : DW'(PROG_WAIT_CYC);
    end else if (state_q == ST_POLL && take && hit && mode_q == MD_INVBIT) begin
      dly_load  = 1'b1;
    end
  end

  pwc_delay #(.W(DW)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .load    (dly_load),
    .count   (dly_count),
    .expired (dly_exp)
  );

  pwc_delay #(.W(LIM_W)) u_limit (
    .clk     (clk),
    .rst     (rst),
    .load    (launch),
    .count   (poll_limit),
    .expired (lim_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      mode_q   <= MD_INVBIT;
      exp_q    <= '0;
      addr_q   <= '0;
      second_q <= 1'b0;
      req_q    <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      to_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      to_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_q   <= mode_in;
            exp_q    <= op_erase ? ERASED : wdata;
            addr_q   <= addr;
            second_q <= 1'b0;
            state_q  <= (mode_in == MD_TIMER) ? ST_WAIT : ST_POLL;
          end
        end
        ST_POLL: begin
          if (!req_q) begin
            if (lim_exp) begin
              to_q    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              req_q <= 1'b1;
            end
          end else if (rd_ack) begin
            req_q <= 1'b0;
            if (hit) state_q <= (mode_q == MD_INVBIT) ? ST_SETTLE : ST_CHECK;
          end
        end
        ST_SETTLE, ST_WAIT: begin
          if (dly_exp) state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!req_q) req_q <= 1'b1;
          else if (rd_ack) begin
            req_q <= 1'b0;
            if (rd_data == exp_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_RECHECK;
            end
          end
        end
        ST_RECHECK: begin
          if (!req_q) req_q <= 1'b1;
          else if (rd_ack) begin
            req_q <= 1'b0;
            if (rd_data != exp_q) begin
              fail_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (second_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              second_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req  = req_q;
  assign rd_addr = addr_q;
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign fail    = fail_q;
  assign timeout = to_q;
endmodule

// File: rtl/pwc_checker.sv
`timescale 1ns/1ps
module pwc_checker
  import pwc_pkg::*;
#(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          rd_req,
  input logic          rd_ack,
  input logic          done,
  input logic          fail,
  input logic          timeout,
  input logic [AW-1:0] rd_addr,
  input pwc_state_t    state
);
  // R8
  outcome_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, fail, timeout}));

  // R8
  outcome_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (done || fail || timeout) |=> !(done || fail || timeout));

  // R8
  outcome_while_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (done || fail || timeout) |-> !busy);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> rd_req);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> $stable(rd_addr));

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(rd_addr));

  // R4
  timer_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !rd_req);

  // R7
  timeout_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> $past(busy));
endmodule

bind flash_done_poller pwc_checker #(.AW(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .rd_req  (rd_req),
  .rd_ack  (rd_ack),
  .done    (done),
  .fail    (fail),
  .timeout (timeout),
  .rd_addr (rd_addr),
  .state   (state_q)
);

// File: tb/flash_done_poller_tb.sv
`timescale 1ns/1ps
module flash_done_poller_tb;
  localparam int AW = 19, LW = 20;
  localparam int SETTLE = 10, PWAIT = 50, EWAIT = 200;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, op_erase = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rd_data = '0;
  logic [LW-1:0] poll_limit = '0;
  logic rd_req, rd_ack = 1'b0, busy, done, fail, timeout;
  logic [AW-1:0] rd_addr;

  int total = 0, bad = 0, cyc = 0;
  int m_busy = 0, m_stale = 0, rd_n = 0, addr_bad = 0, start_cyc = 0;
  logic [7:0] m_true = '0;
  logic [AW-1:0] m_addr = '0;
  int reqcyc [0:1023];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_done_poller #(.ADDR_W(AW), .LIM_W(LW), .SETTLE_CYC(SETTLE),
    .PROG_WAIT_CYC(PWAIT), .ERASE_WAIT_CYC(EWAIT)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .op_erase(op_erase),
    .addr(addr), .wdata(wdata), .poll_limit(poll_limit), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy),
    .done(done), .fail(fail), .timeout(timeout));

  // Flash model: busy reads flip bit 7, toggle bit 6, vary low bits; then stale, then true.
  always @(negedge clk) begin
    if (rd_ack) rd_ack = 1'b0;
    else if (rd_req) begin
      if (rd_n < m_busy) begin
        rd_data = {~m_true[7], rd_n[0], rd_n[5:0]};
      end else if (rd_n < m_busy + m_stale) begin
        rd_data = m_true ^ 8'h01;
      end else begin
        rd_data = m_true;
      end
      if (rd_addr !== m_addr) addr_bad++;
      if (rd_n < 1024) reqcyc[rd_n] = cyc;
      rd_n++;
      rd_ack = 1'b1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // result: 1 done, 2 fail, 3 timeout, 0 none
  task automatic run_op(input int md, input bit er, input logic [7:0] wd, input logic [7:0] tv,
                        input int nb, input int ns, input int lim, input bit mid_start,
                        output int res, output int nreads);
    int ticks;
    @(negedge clk);
    m_true = tv; m_busy = nb; m_stale = ns; rd_n = 0; addr_bad = 0;
    m_addr = AW'(19'h2A5C3 ^ (md * 7));
    addr = m_addr; mode = 2'(md); op_erase = er; wdata = wd; poll_limit = LW'(lim);
    start = 1'b1; start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    res = 0; ticks = 0;
    while (res == 0 && ticks < 5000) begin
      @(negedge clk);
      ticks++;
      if (mid_start && ticks == 5) begin
        addr = ~m_addr; mode = 2'd3; op_erase = 1'b1; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done + fail + timeout > 1) chk("R8 exclusive", done + fail + timeout, 1);
      if (done)    res = 1;
      if (fail)    res = 2;
      if (timeout) res = 3;
      if (res != 0) chk("R8 busy low at pulse", busy, 0);
    end
    @(negedge clk);
    chk("R8 pulse one cycle", done | fail | timeout, 0);
    nreads = rd_n;
    chk("R10 read address", addr_bad, 0);
  endtask

  task automatic t_reset();
    chk("R8 reset busy", busy, 0);
    chk("R8 reset pulses", done | fail | timeout, 0);
    chk("R10 reset rd_req", rd_req, 0);
  endtask

  task automatic t_poll();
    int r, n;
    run_op(0, 0, 8'hA5, 8'hA5, 5, 0, 2000, 0, r, n);
    chk("R1 poll result", r, 1);
    chk("R1 poll reads", n, 7);
    chk("R1 settle gap", (reqcyc[6] - reqcyc[5] >= SETTLE) ? 1 : 0, 1);
    run_op(0, 0, 8'h12, 8'h12, 0, 0, 2000, 0, r, n);
    chk("R1 immediate result", r, 1);
    chk("R1 immediate reads", n, 2);
  endtask

  task automatic t_toggle();
    int r, n;
    run_op(1, 0, 8'h5A, 8'h5A, 4, 0, 2000, 0, r, n);
    chk("R2 toggle even result", r, 1);
    chk("R2 toggle even reads", n, 6);
    run_op(1, 0, 8'h5A, 8'h5A, 3, 0, 2000, 0, r, n);
    chk("R2 toggle odd result", r, 1);
    chk("R2 toggle odd reads", n, 6);
    run_op(1, 0, 8'h33, 8'h33, 0, 0, 2000, 0, r, n);
    chk("R2 toggle first read no hit", n, 3);
  endtask

  task automatic t_repeat();
    int r, n;
    run_op(2, 0, 8'h3C, 8'h3C, 6, 0, 2000, 0, r, n);
    chk("R3 repeat result", r, 1);
    chk("R3 repeat reads", n, 9);
  endtask

  task automatic t_timer();
    int r, n;
    run_op(3, 0, 8'h77, 8'h77, 0, 0, 2000, 0, r, n);
    chk("R4 timer program result", r, 1);
    chk("R4 timer program reads", n, 1);
    chk("R4 program wait", (reqcyc[0] - start_cyc >= PWAIT) ? 1 : 0, 1);
    run_op(3, 1, 8'h00, 8'hFF, 0, 0, 2000, 0, r, n);
    chk("R4 timer erase result", r, 1);
    chk("R4 erase wait", (reqcyc[0] - start_cyc >= EWAIT) ? 1 : 0, 1);
  endtask

  task automatic t_erase();
    int r, n;
    run_op(0, 1, 8'h00, 8'hFF, 3, 0, 2000, 0, r, n);
    chk("R5 erase expects FF", r, 1);
    chk("R5 erase reads", n, 5);
  endtask

  task automatic t_retry();
    int r, n;
    run_op(0, 0, 8'hC6, 8'hC6, 2, 2, 2000, 0, r, n);
    chk("R6 retry pass result", r, 1);
    chk("R6 retry pass reads", n, 6);
    run_op(0, 0, 8'hC6, 8'hC6, 2, 3, 2000, 0, r, n);
    chk("R6 retry fail result", r, 2);
    chk("R6 retry fail reads", n, 5);
  endtask

  task automatic t_timeout();
    int r, n;
    run_op(0, 0, 8'h81, 8'h81, 100000, 0, 60, 0, r, n);
    chk("R7 poll timeout", r, 3);
    chk("R7 no confirm read", (n < 60) ? 1 : 0, 1);
    run_op(2, 0, 8'h81, 8'h81, 100000, 0, 40, 0, r, n);
    chk("R7 repeat timeout", r, 3);
    m_busy = 0;
  endtask

  task automatic t_ignore();
    int r, n;
    run_op(0, 0, 8'h4E, 8'h4E, 20, 0, 2000, 1, r, n);
    chk("R9 busy start result", r, 1);
    chk("R9 busy start reads", n, 22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_poll();
    t_toggle();
    t_repeat();
    t_timer();
    t_erase();
    t_retry();
    t_timeout();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule